// File: doc/BRIEF.md
# Descriptor-Driven Configuration Copy Engine

This engine moves bytes out of a configuration data item into system memory on behalf of software. Software writes the memory address of a 16-byte descriptor into a 64-bit trigger register. The engine then reads the descriptor through a memory master port and decodes its control word. Depending on the control bits, it copies bytes from the item at the current item offset to a target address, or it advances the offset without copying. It finishes by writing a completion status word back over the control field of the descriptor.

The item storage is outside the block. The engine presents an offset (`item_off`) and takes one byte back combinationally (`item_rd_data`), together with the item size. The memory port is a valid/ready request channel with single-beat accesses. The engine raises `mem_valid` and holds every request field stable until `mem_ready` is seen high on a clock edge. Read data and the fault flag are sampled only in that acceptance cycle, so the memory side may stall for any number of cycles. The engine never has more than one request outstanding.

Top module: `cfg_dma_engine`

## Requirements
- R1: `feature_map` bit 1 is 1, which reports that the copy engine is present. The other bits come from the `FEAT_OTHER` parameter, which defaults to 0.
- R2: `trig_rdata` returns the raw 64-bit trigger register and is zero after reset. The register holds its value big-endian: the descriptor address is {swap(raw[63:32]), swap(raw[31:0])}, where swap reverses the four bytes, so `trig_wdata[7:0]` is the most significant byte of the low half.
- R3: When idle, a write to the low half (`trig_lo_we`) starts an operation and `busy` is high from the next cycle. A write to the high half alone (`trig_hi_we` only) latches bits 63:32 and starts nothing. Both enables in one cycle load all 64 bits and start.
- R4: Trigger writes that arrive while `busy` is high change nothing.
- R5: The descriptor is fetched with four 32-bit reads at D, D+4, D+8 and D+12. Lane k (bits 8k+7:8k) holds the byte at address+k. Each field is big-endian, in this order: control, length, target high word, target low word.
- R6: If control bit 1 (read) is set, the engine issues `length` single-byte writes to target T+i. Each write carries the byte replicated on all four lanes and a strobe of `1 << addr[1:0]`. The byte is taken from the item at the current offset, and the offset grows by one for each accepted byte. A length of zero produces no writes.
- R7: A byte at an offset equal to or beyond `item_size` is copied as zero.
- R8: If read is clear and control bit 2 (skip) is set, the offset grows by `length` and no memory write other than the status write occurs.
- R9: The status write goes to address D with strobe 4'hF. Its data is 0 on success, or 32'h0100_0000 (control bit 0, error, in big-endian form) when neither read nor skip is set or when `mem_err` comes with any accepted access. After a fault the engine issues no further copy writes.
- R10: A request with `mem_valid` high keeps its address, direction and strobe until accepted. No request is made while `busy` is low.
- R11: `busy` stays high until the status write is accepted. The trigger register reads zero from the cycle `busy` falls.
- R12: `item_select_clr` sets the offset to zero when idle and is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| trig_lo_we | input | 1 | write strobe for trigger bits 31:0 |
| trig_hi_we | input | 1 | write strobe for trigger bits 63:32 |
| trig_wdata | input | 64 | trigger write data, big-endian halves |
| trig_rdata | output | 64 | raw trigger register value |
| feature_map | output | FEAT_W | capability bits, bit 1 = engine present |
| busy | output | 1 | operation in progress |
| item_select_clr | input | 1 | new item selected: offset to zero |
| item_size | input | OFF_W | size of the selected item in bytes |
| item_off | output | OFF_W | current item offset |
| item_rd_data | input | 8 | item byte at `item_off` |
| mem_valid | output | 1 | memory request valid |
| mem_ready | input | 1 | memory request accepted |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 64 | byte address |
| mem_wdata | output | 32 | write data |
| mem_wstrb | output | 4 | byte-lane write enables |
| mem_rdata | input | 32 | read data, valid with acceptance |
| mem_err | input | 1 | access fault, valid with acceptance |

## Verification
The assertions take for granted that `rst_n` is held for at least one edge, and that `mem_rdata` and `mem_err` matter only in a cycle where `mem_ready` is high. They also assume that the descriptor address is word aligned, so every fetch is one whole word. The stimulus places all descriptors on 4-byte boundaries and drives memory responses only in the half cycle after a request is seen, with `mem_err` raised only on an accepted access. It never pulses `item_select_clr` in the same cycle as a trigger write. Back-pressure is varied by a pseudo-random `mem_ready` in some runs.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECIDE,
    ST_COPY,
    ST_SKIP,
    ST_STATUS
  } seq_state_e;

  localparam int CTL_ERR  = 0;
  localparam int CTL_READ = 1;
  localparam int CTL_SKIP = 2;

  // status word with only the error bit set, as bytes 00 00 00 01 in memory
  localparam logic [31:0] STATUS_ERR_WORD = 32'h0100_0000;

  function automatic logic [31:0] swap4(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction
endpackage

// File: rtl/cfgdma_trig_reg.sv
module cfgdma_trig_reg
  import cfgdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lo_we,
  input  logic        hi_we,
  input  logic [63:0] wdata,
  input  logic        busy,
  input  logic        done,
  output logic [63:0] raw,
  output logic [63:0] desc_addr,
  output logic        start
);
  logic [63:0] raw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q <= '0;
    end else if (done) begin
      raw_q <= '0;
    end else if (!busy) begin
      if (hi_we) raw_q[63:32] <= wdata[63:32];
      if (lo_we) raw_q[31:0]  <= wdata[31:0];
    end
  end

  assign raw       = raw_q;
  assign desc_addr = {swap4(raw_q[63:32]), swap4(raw_q[31:0])};
  assign start     = lo_we && !busy;
endmodule

// File: rtl/cfgdma_item_cursor.sv
module cfgdma_item_cursor #(
  parameter int OFF_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             jump,
  input  logic [OFF_W-1:0] jump_len,
  input  logic [OFF_W-1:0] size,
  input  logic [7:0]       raw_byte,
  output logic [OFF_W-1:0] off,
  output logic [7:0]       byte_out
);
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     off_q <= '0;
    else if (clr)   off_q <= '0;
    else if (step)  off_q <= off_q + OFF_W'(1);
    else if (jump)  off_q <= off_q + jump_len;
  end

  assign off      = off_q;
  assign byte_out = (off_q < size) ? raw_byte : 8'h00;
endmodule

// File: rtl/cfgdma_seq.sv
module cfgdma_seq
  import cfgdma_pkg::*;
#(
  parameter int OFF_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [63:0]      desc_addr,
  input  logic [7:0]       item_byte,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic             mem_we,
  output logic [63:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  output logic [3:0]       mem_wstrb,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_err,
  output logic             step,
  output logic             jump,
  output logic [OFF_W-1:0] jump_len,
  output logic             done,
  output logic             busy
);
  seq_state_e  state;
  logic [1:0]  idx;
  logic        rd_bit, sk_bit, err_q;
  logic [31:0] len, rem;
  logic [63:0] tgt;
  logic        acc;
  logic [31:0] word;

  assign word = swap4(mem_rdata);
  assign acc  = mem_valid && mem_ready;

  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    mem_wstrb = '0;
    unique case (state)
      ST_FETCH: begin
        mem_valid = 1'b1;
        mem_addr  = desc_addr + {60'd0, idx, 2'b00};
      end
      ST_COPY: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = tgt;
        mem_wdata = {4{item_byte}};
        mem_wstrb = 4'b0001 << tgt[1:0];
      end
      ST_STATUS: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_addr;
        mem_wdata = err_q ? STATUS_ERR_WORD : 32'h0;
        mem_wstrb = 4'hF;
      end
      default: ;
    endcase
  end

  assign step     = (state == ST_COPY) && acc && !mem_err;
  assign jump     = (state == ST_SKIP);
  assign jump_len = OFF_W'(len);
  assign done     = (state == ST_STATUS) && acc;
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      idx    <= '0;
      rd_bit <= 1'b0;
      sk_bit <= 1'b0;
      err_q  <= 1'b0;
      len    <= '0;
      rem    <= '0;
      tgt    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_FETCH;
          idx   <= '0;
          err_q <= 1'b0;
        end
        ST_FETCH: if (acc) begin
          if (mem_err) begin
            err_q <= 1'b1;
            state <= ST_STATUS;
          end else begin
            idx <= idx + 2'd1;
            unique case (idx)
              2'd0: begin
                rd_bit <= word[CTL_READ];
                sk_bit <= word[CTL_SKIP];
              end
              2'd1: len <= word;
              2'd2: tgt[63:32] <= word;
              default: begin
                tgt[31:0] <= word;
                state     <= ST_DECIDE;
              end
            endcase
          end
        end
        ST_DECIDE: begin
          rem <= len;
          if (rd_bit) begin
            state <= (len == 32'd0) ? ST_STATUS : ST_COPY;
          end else if (sk_bit) begin
            state <= ST_SKIP;
          end else begin
            err_q <= 1'b1;
            state <= ST_STATUS;
          end
        end
        ST_COPY: if (acc) begin
          if (mem_err) begin
            err_q <= 1'b1;
            state <= ST_STATUS;
          end else begin
            tgt <= tgt + 64'd1;
            rem <= rem - 32'd1;
            if (rem == 32'd1) state <= ST_STATUS;
          end
        end
        ST_SKIP:   state <= ST_STATUS;
        ST_STATUS: if (acc) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine
  import cfgdma_pkg::*;
#(
  parameter int               OFF_W      = 32,
  parameter int               FEAT_W     = 32,
  parameter logic [FEAT_W-1:0] FEAT_OTHER = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_lo_we,
  input  logic              trig_hi_we,
  input  logic [63:0]       trig_wdata,
  output logic [63:0]       trig_rdata,
  output logic [FEAT_W-1:0] feature_map,
  output logic              busy,
  input  logic              item_select_clr,
  input  logic [OFF_W-1:0]  item_size,
  output logic [OFF_W-1:0]  item_off,
  input  logic [7:0]        item_rd_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [63:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_wstrb,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_err
);
  localparam int DMA_FEAT_BIT = 1;

  logic [63:0]      desc_addr;
  logic             start, done, step, jump, busy_i;
  logic [OFF_W-1:0] jump_len;
  logic [7:0]       item_byte;

  always_comb begin
    feature_map               = FEAT_OTHER;
    feature_map[DMA_FEAT_BIT] = 1'b1;
  end

  cfgdma_trig_reg u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .lo_we     (trig_lo_we),
    .hi_we     (trig_hi_we),
    .wdata     (trig_wdata),
    .busy      (busy_i),
    .done      (done),
    .raw       (trig_rdata),
    .desc_addr (desc_addr),
    .start     (start)
  );

  cfgdma_item_cursor #(.OFF_W(OFF_W)) u_cursor (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (item_select_clr && !busy_i),
    .step     (step),
    .jump     (jump),
    .jump_len (jump_len),
    .size     (item_size),
    .raw_byte (item_rd_data),
    .off      (item_off),
    .byte_out (item_byte)
  );

  cfgdma_seq #(.OFF_W(OFF_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .desc_addr (desc_addr),
    .item_byte (item_byte),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_wstrb (mem_wstrb),
    .mem_rdata (mem_rdata),
    .mem_err   (mem_err),
    .step      (step),
    .jump      (jump),
    .jump_len  (jump_len),
    .done      (done),
    .busy      (busy_i)
  );

  assign busy = busy_i;
endmodule

// File: rtl/cfgdma_chk.sv
module cfgdma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        trig_lo_we,
  input logic        trig_hi_we,
  input logic [63:0] trig_rdata,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic        mem_we,
  input logic [63:0] mem_addr,
  input logic [3:0]  mem_wstrb
);
  // R10
  idle_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> busy);

  // R10
  hold_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wstrb));

  // R11
  clear_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> trig_rdata == 64'd0);

  // R3
  hi_only_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && trig_hi_we && !trig_lo_we |=> !busy);

  // R3
  lo_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && trig_lo_we |=> busy);

  // R4
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (trig_lo_we || trig_hi_we) && !(mem_valid && mem_ready) |=> $stable(trig_rdata));

  // R6
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we && mem_wstrb != 4'hF |-> $countones(mem_wstrb) == 1);
endmodule

bind cfg_dma_engine cfgdma_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .trig_lo_we (trig_lo_we),
  .trig_hi_we (trig_hi_we),
  .trig_rdata (trig_rdata),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wstrb  (mem_wstrb)
);

// File: tb/cfg_dma_engine_test.sv
module cfg_dma_engine_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        trig_lo_we, trig_hi_we;
  logic [63:0] trig_wdata, trig_rdata;
  logic [31:0] feature_map;
  logic        busy;
  logic        item_select_clr;
  logic [31:0] item_size, item_off;
  logic [7:0]  item_rd_data;
  logic        mem_valid, mem_ready, mem_we, mem_err;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [3:0]  mem_wstrb;

  cfg_dma_engine uut (.*);

  logic [7:0] item_mem [64];
  assign item_rd_data = item_mem[item_off[5:0]];

  logic [7:0] mem [logic [63:0]];

  typedef struct {
    int          kind;   // 0 fetch, 1 byte copy, 2 status
    logic        we;
    logic [63:0] addr;
    logic [31:0] wdata;
    logic [3:0]  strb;
  } acc_t;
  acc_t q[$];

  int          checks = 0, failures = 0;
  logic        exp_busy = 1'b0, off_unsure = 1'b0, rand_ready = 1'b0;
  logic [63:0] exp_raw = '0, cur_desc = '0, fault_addr = '0;
  logic        fault_en = 1'b0;
  logic [31:0] exp_off = '0;
  int          nfetch = 0;

  function automatic logic [31:0] sw4(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [7:0] mb(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  function automatic logic [31:0] get32be(input logic [63:0] a);
    return {mb(a), mb(a + 1), mb(a + 2), mb(a + 3)};
  endfunction

  task automatic put32be(input logic [63:0] a, input logic [31:0] v);
    mem[a] = v[31:24]; mem[a + 1] = v[23:16]; mem[a + 2] = v[15:8]; mem[a + 3] = v[7:0];
  endtask

  task automatic put_desc(input logic [63:0] d, input logic [31:0] ctl, input logic [31:0] len,
                          input logic [63:0] tgt);
    put32be(d, ctl); put32be(d + 4, len); put32be(d + 8, tgt[63:32]); put32be(d + 12, tgt[31:0]);
  endtask

  task automatic fill(input logic [63:0] a, input int n, input logic [7:0] v);
    for (int i = 0; i < n; i++) mem[a + 64'(i)] = v;
  endtask

  function automatic logic [7:0] item_at(input logic [31:0] o);
    return (o < item_size) ? item_mem[o[5:0]] : 8'h00;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic push_status(input bit err);
    acc_t e;
    e.kind = 2; e.we = 1'b1; e.addr = cur_desc; e.strb = 4'hF;
    e.wdata = err ? 32'h0100_0000 : 32'h0;
    q.push_back(e);
  endtask

  task automatic decide();
    logic [31:0] ctl, len;
    logic [63:0] tgt;
    acc_t e;
    ctl = get32be(cur_desc);
    len = get32be(cur_desc + 4);
    tgt = {get32be(cur_desc + 8), get32be(cur_desc + 12)};
    if (ctl[1]) begin
      for (int i = 0; i < int'(len); i++) begin
        logic [63:0] a;
        logic [7:0]  b;
        a = tgt + 64'(i);
        b = item_at(exp_off + 32'(i));
        e.kind = 1; e.we = 1'b1; e.addr = a; e.wdata = {4{b}}; e.strb = 4'b0001 << a[1:0];
        q.push_back(e);
      end
      push_status(1'b0);
    end else if (ctl[2]) begin
      exp_off    = exp_off + len;
      off_unsure = 1'b1;
      push_status(1'b0);
    end else begin
      push_status(1'b1);
    end
  endtask

  task automatic handle_access();
    acc_t e;
    logic fault;
    fault   = fault_en && (mem_addr == fault_addr);
    mem_err = fault;
    if (!mem_we) mem_rdata = {mb({mem_addr[63:2], 2'b11}), mb({mem_addr[63:2], 2'b10}),
                              mb({mem_addr[63:2], 2'b01}), mb({mem_addr[63:2], 2'b00})};
    else if (!fault)
      for (int k = 0; k < 4; k++)
        if (mem_wstrb[k]) mem[{mem_addr[63:2], 2'(k)}] = mem_wdata[8*k +: 8];
    if (q.size() == 0) begin
      chk(1'b0, "R10 unexpected access", mem_addr, 64'd0);
      return;
    end
    e = q.pop_front();
    chk(mem_we == e.we && mem_addr == e.addr,
        e.kind == 0 ? "R5 fetch addr" : (e.kind == 1 ? "R6 copy addr" : "R9 status addr"),
        {mem_we, mem_addr[62:0]}, {e.we, e.addr[62:0]});
    if (e.we) chk(mem_wdata == e.wdata && mem_wstrb == e.strb,
                  e.kind == 1 ? "R6 R7 copy data" : "R9 status data",
                  {28'd0, mem_wstrb, mem_wdata}, {28'd0, e.strb, e.wdata});
    if (e.kind == 2) begin
      exp_busy   = 1'b0;
      exp_raw    = '0;
      off_unsure = 1'b0;
    end else if (fault) begin
      q.delete();
      push_status(1'b1);
    end else if (e.kind == 1) begin
      exp_off = exp_off + 1;
    end else begin
      nfetch++;
      if (nfetch == 4) decide();
    end
  endtask

  // memory responder and cycle-by-cycle reference model
  initial begin
    mem_ready = 1'b0; mem_rdata = '0; mem_err = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        chk(busy == exp_busy, "R11 busy", {63'd0, busy}, {63'd0, exp_busy});
        chk(trig_rdata == exp_raw, "R2 R4 trigger register", trig_rdata, exp_raw);
        if (!off_unsure) chk(item_off == exp_off, "R6 R8 R12 offset", {32'd0, item_off}, {32'd0, exp_off});
        chk(!(mem_valid && !exp_busy), "R10 access while idle", {63'd0, mem_valid}, 64'd0);
      end
      #1;
      mem_ready = rand_ready ? ($urandom_range(0, 3) != 0) : 1'b1;
      mem_err   = 1'b0;
      mem_rdata = '0;
      if (rst_n) begin
        if (!exp_busy) begin
          if (trig_hi_we) exp_raw[63:32] = trig_wdata[63:32];
          if (trig_lo_we) begin
            exp_raw[31:0] = trig_wdata[31:0];
            exp_busy = 1'b1;
            cur_desc = {sw4(exp_raw[63:32]), sw4(exp_raw[31:0])};
            nfetch   = 0;
            for (int i = 0; i < 4; i++) begin
              acc_t e;
              e.kind = 0; e.we = 1'b0; e.addr = cur_desc + 64'(4 * i); e.wdata = '0; e.strb = '0;
              q.push_back(e);
            end
          end
          if (item_select_clr) exp_off = '0;
        end
        if (mem_valid && mem_ready) handle_access();
      end
    end
  end

  task automatic trig(input bit lo, input bit hi, input logic [63:0] a);
    @(negedge clk);
    trig_lo_we = lo; trig_hi_we = hi;
    trig_wdata = {sw4(a[63:32]), sw4(a[31:0])};
    @(negedge clk);
    trig_lo_we = 1'b0; trig_hi_we = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(q.size() == 0, "R9 all accesses issued", 64'(q.size()), 64'd0);
  endtask

  task automatic sel_clr();
    @(negedge clk); item_select_clr = 1'b1;
    @(negedge clk); item_select_clr = 1'b0;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < 64; i++) item_mem[i] = 8'(i * 5 + 17);
    rst_n = 1'b0; trig_lo_we = 1'b0; trig_hi_we = 1'b0; trig_wdata = '0;
    item_select_clr = 1'b0; item_size = 32'd40;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk(busy == 1'b0 && mem_valid == 1'b0, "R11 reset idle", {62'd0, busy, mem_valid}, 64'd0);
    chk(trig_rdata == 64'd0, "R2 reset register", trig_rdata, 64'd0);
    chk(feature_map[1] == 1'b1, "R1 feature bit", {32'd0, feature_map}, 64'd2);
    chk(feature_map == 32'd2, "R1 other feature bits", {32'd0, feature_map}, 64'd2);

    // read of 6 bytes to an unaligned target
    fill(64'h2000, 9, 8'hAA);
    put_desc(64'h100, 32'h2, 32'd6, 64'h2001);
    trig(1'b1, 1'b0, 64'h100);
    wait_idle();
    for (int i = 0; i < 6; i++) chk(mb(64'h2001 + 64'(i)) == item_mem[i], "R6 copied byte",
                                    {56'd0, mb(64'h2001 + 64'(i))}, {56'd0, item_mem[i]});
    chk(mb(64'h2000) == 8'hAA && mb(64'h2007) == 8'hAA, "R6 no stray write", {56'd0, mb(64'h2007)}, 64'hAA);
    chk(get32be(64'h100) == 32'd0, "R9 success status", {32'd0, get32be(64'h100)}, 64'd0);
    chk(item_off == 32'd6, "R6 offset after read", {32'd0, item_off}, 64'd6);

    // skip of 10
    fill(64'h3000, 4, 8'hAA);
    put_desc(64'h300, 32'h4, 32'd10, 64'h3000);
    trig(1'b1, 1'b0, 64'h300);
    wait_idle();
    chk(item_off == 32'd16, "R8 skip offset", {32'd0, item_off}, 64'd16);
    chk(mb(64'h3000) == 8'hAA, "R8 no write on skip", {56'd0, mb(64'h3000)}, 64'hAA);

    // skip to 36, then read across the item end
    put_desc(64'h340, 32'h4, 32'd20, 64'h0);
    trig(1'b1, 1'b0, 64'h340);
    wait_idle();
    fill(64'h4000, 8, 8'hAA);
    put_desc(64'h400, 32'h2, 32'd8, 64'h4000);
    trig(1'b1, 1'b0, 64'h400);
    wait_idle();
    for (int i = 0; i < 8; i++) begin
      logic [7:0] ex;
      ex = (i < 4) ? item_mem[36 + i] : 8'h00;
      chk(mb(64'h4000 + 64'(i)) == ex, "R7 past-end bytes", {56'd0, mb(64'h4000 + 64'(i))}, {56'd0, ex});
    end

    // offset clear when idle
    sel_clr();
    @(negedge clk);
    chk(item_off == 32'd0, "R12 clear when idle", {32'd0, item_off}, 64'd0);

    // high half alone, then low half
    put_desc(64'h1_0000_0200, 32'h2, 32'd2, 64'h5000);
    trig(1'b0, 1'b1, 64'h1_0000_0200);
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R3 high half does not start", {63'd0, busy}, 64'd0);
    chk(trig_rdata[63:32] == sw4(32'h1), "R2 R3 high half latched", trig_rdata, {sw4(32'h1), 32'd0});
    trig(1'b1, 1'b0, 64'h1_0000_0200);
    wait_idle();
    chk(mb(64'h5000) == item_mem[0] && mb(64'h5001) == item_mem[1], "R3 64-bit descriptor read",
        {48'd0, mb(64'h5000), mb(64'h5001)}, {48'd0, item_mem[0], item_mem[1]});
    chk(get32be(64'h1_0000_0200) == 32'd0, "R9 status at high address", {32'd0, get32be(64'h1_0000_0200)}, 64'd0);

    // single 64-bit write, zero length read
    put_desc(64'h2_0000_0300, 32'h2, 32'd0, 64'h6000);
    trig(1'b1, 1'b1, 64'h2_0000_0300);
    wait_idle();
    chk(get32be(64'h2_0000_0300) == 32'd0, "R3 R6 zero-length status", {32'd0, get32be(64'h2_0000_0300)}, 64'd0);
    chk(item_off == 32'd2, "R6 zero length keeps offset", {32'd0, item_off}, 64'd2);

    // invalid control: only the error bit set
    put_desc(64'h600, 32'h1, 32'd4, 64'h6100);
    trig(1'b1, 1'b0, 64'h600);
    wait_idle();
    chk(get32be(64'h600) == 32'd1, "R9 invalid control status", {32'd0, get32be(64'h600)}, 64'd1);
    chk(item_off == 32'd2, "R9 invalid keeps offset", {32'd0, item_off}, 64'd2);

    // fault on the third copied byte
    fill(64'h7000, 5, 8'hAA);
    fault_en = 1'b1; fault_addr = 64'h7002;
    put_desc(64'h700, 32'h2, 32'd5, 64'h7000);
    trig(1'b1, 1'b0, 64'h700);
    wait_idle();
    fault_en = 1'b0;
    chk(get32be(64'h700) == 32'd1, "R9 fault status", {32'd0, get32be(64'h700)}, 64'd1);
    chk(item_off == 32'd4, "R9 fault offset", {32'd0, item_off}, 64'd4);
    chk(mb(64'h7003) == 8'hAA && mb(64'h7004) == 8'hAA, "R9 no copy after fault", {56'd0, mb(64'h7003)}, 64'hAA);

    // writes and offset clear while busy, with back-pressure
    rand_ready = 1'b1;
    put_desc(64'h900, 32'h2, 32'd1, 64'h9900);
    put_desc(64'h800, 32'h2, 32'd12, 64'h8000);
    trig(1'b1, 1'b0, 64'h800);
    repeat (2) @(negedge clk);
    trig(1'b1, 1'b1, 64'h900);
    sel_clr();
    wait_idle();
    chk(item_off == 32'd16, "R12 clear ignored while busy", {32'd0, item_off}, 64'd16);
    chk(get32be(64'h900) == 32'h2, "R4 busy write started nothing", {32'd0, get32be(64'h900)}, 64'h2);
    chk(get32be(64'h800) == 32'd0, "R10 status under back-pressure", {32'd0, get32be(64'h800)}, 64'd0);

    // full item under back-pressure
    sel_clr();
    put_desc(64'hA00, 32'h6, 32'd40, 64'hA000);
    trig(1'b1, 1'b0, 64'hA00);
    wait_idle();
    for (int i = 0; i < 40; i++) chk(mb(64'hA000 + 64'(i)) == item_mem[i], "R6 R10 full copy",
                                     {56'd0, mb(64'hA000 + 64'(i))}, {56'd0, item_mem[i]});
    chk(item_off == 32'd40, "R6 offset after full copy", {32'd0, item_off}, 64'd40);
    rand_ready = 1'b0;

    repeat (3) @(negedge clk);
    summary();
  end
endmodule